// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a single line and hands the received byte to software through a small register port. It supports two frame formats: an 8-bit format with one stop bit, and a 9-bit format where an extra bit follows the eight data bits. In the 9-bit format that extra bit tells an address frame (bit high) from a data frame (bit low). This allows one master to talk to many receivers on a shared line.

A hardware filter decides whether a finished frame is accepted. An accepted frame loads the data registers and raises the receive flag. In 9-bit mode with the filter on, only address frames are candidates. A candidate is accepted when it matches either the node's own masked address or its broadcast pattern, so software is interrupted only for frames meant for this node. In 8-bit mode, the same enable instead makes acceptance depend on a good stop bit. The bit timing comes from an external tick at 16 times the bit rate. Each bit is resolved by a majority vote of three samples taken around its centre.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: In 8-bit mode with the filter off, a frame is a low start bit, then 8 data bits least-significant first, then a stop bit. Each bit is taken as the majority of three samples near its centre. On completion the byte appears on `rxData`, the sampled stop level appears on `rxBit9`, and `rxFlag` is set.
- R2: In 9-bit mode (control bit 0 = 1), a ninth bit follows the eight data bits and precedes the stop bit. With the filter off, every frame is accepted and the ninth bit is stored on `rxBit9`.
- R3: A stop bit sampled low sets `frameErr` in either mode, whether or not the frame is accepted. `frameErr` stays set until a control write with bit 3 = 1.
- R4: In 8-bit mode with the filter on (control bit 1 = 1), a frame whose stop bit samples low is not accepted: `rxFlag`, `rxData` and `rxBit9` keep their previous values.
- R5: In 9-bit mode with the filter on, a frame whose ninth bit is 0 is never accepted, and `rxData`, `rxBit9` and `rxFlag` keep their previous values.
- R6: In 9-bit mode with the filter on, an address frame is accepted when `(byte & mask) == (slaveAddr & mask)`. Mask bits that are 0 are don't-cares. Example: address 0xC0 with mask 0xFD accepts 0xC2, while mask 0xFE rejects 0xC2.
- R7: An address frame is also accepted when the byte has a 1 in every position where `slaveAddr | mask` is 1. A byte of 0xFF therefore always matches.
- R8: After reset, `rxData`, `rxBit9`, `rxFlag` and `frameErr` are 0 and `rxIn` idle is expected high. The mode is 8-bit with the filter off, and the slave address and mask are 0, so with the filter on every address frame is accepted.
- R9: Register port: a write with `regSel` 0 loads control (bit 0 = 9-bit mode, bit 1 = filter enable). Setting bit 2 in that write clears `rxFlag` and setting bit 3 clears `frameErr`; if a frame completes in the same cycle, the completing frame's set wins. `regSel` 1 loads the slave address and `regSel` 2 loads the mask.
- R10: `rxFlag` stays set until cleared through the register port, and `irq` always equals `rxFlag`.
- R11: A start bit that has returned high by its centre sample is discarded as a glitch, with no change to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16x bit rate |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 slave address, 2 mask |
| regWrData | input | 8 | Register write data |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit (9-bit mode) or stop level (8-bit mode) of last accepted frame |
| rxFlag | output | 1 | Receive flag, sticky |
| frameErr | output | 1 | Framing error flag, sticky |
| irq | output | 1 | Interrupt request, follows rxFlag |

## Verification
A frame's results are decided at the centre of its stop bit, about 9 ticks into it. The stop-centre decision registers `rxData`, `rxBit9`, `rxFlag` and `frameErr` on the following clock edge, and the line is first seen through two synchronizer flops. The bench therefore checks nothing until the whole stop bit plus three idle bit times have passed, by which point every output has long settled. Register writes take effect on the next edge. Each flag clear is followed by at least one further clock before the next sample. Every sample is taken on a falling clock edge.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int REG_SEL_W = 2;
  localparam logic [REG_SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [REG_SEL_W-1:0] SEL_ADDR = 2'd1;
  localparam logic [REG_SEL_W-1:0] SEL_MASK = 2'd2;

  // control bit positions
  localparam int CB_MODE9  = 0;
  localparam int CB_FILTER = 1;
  localparam int CB_CLRFLG = 2;
  localparam int CB_CLRERR = 3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  // strobes from bit-timing control to the datapath
  typedef struct packed {
    logic shift;   // a data bit has been resolved
    logic ninth;   // the resolved bit is the ninth bit
    logic bitVal;  // resolved level
    logic done;    // stop bit resolved, frame complete
    logic stopOk;  // stop level
  } rxStrobe_t;
endpackage

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic       mode9,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int MID   = OVS / 2;
  localparam logic [CNT_W-1:0] T_S0   = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] T_S1   = CNT_W'(MID);
  localparam logic [CNT_W-1:0] T_VOTE = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] T_END  = CNT_W'(OVS - 1);

  logic rxS1, rxS2;
  logic smp0, smp1;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastIdx;
  rxState_t state;
  logic vote, voteNow, bitEnd;

  assign vote    = (smp0 & smp1) | (smp0 & rxS2) | (smp1 & rxS2);
  assign voteNow = baudTick && (state != RX_IDLE) && (tickCnt == T_VOTE);
  assign bitEnd  = baudTick && (state != RX_IDLE) && (tickCnt == T_END);
  assign lastIdx = mode9 ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
    end else begin
      rxS1 <= rxIn;
      rxS2 <= rxS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      smp0    <= 1'b1;
      smp1    <= 1'b1;
    end else if (baudTick) begin
      if (state == RX_IDLE) begin
        tickCnt <= '0;
        if (!rxS2) state <= RX_START;
      end else begin
        tickCnt <= (tickCnt == T_END) ? '0 : tickCnt + 1'b1;
        if (tickCnt == T_S0) smp0 <= rxS2;
        if (tickCnt == T_S1) smp1 <= rxS2;
        if (voteNow) begin
          if (state == RX_START && vote) state <= RX_IDLE;
          if (state == RX_STOP) state <= RX_IDLE;
        end
        if (bitEnd) begin
          case (state)
            RX_START: begin
              state  <= RX_DATA;
              bitCnt <= '0;
            end
            RX_DATA: begin
              if (bitCnt == lastIdx) state <= RX_STOP;
              else bitCnt <= bitCnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.bitVal = vote;
    strobe.stopOk = vote;
    strobe.shift  = voteNow && (state == RX_DATA);
    strobe.ninth  = (bitCnt == BIT_W'(DATA_W));
    strobe.done   = voteNow && (state == RX_STOP);
  end
endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [DATA_W-1:0]    regWrData,
  output logic                 mode9,
  output logic                 filterEn,
  output logic [DATA_W-1:0]    rxData,
  output logic                 rxBit9,
  output logic                 rxFlag,
  output logic                 frameErr
);
  logic [DATA_W-1:0] shiftReg;
  logic              ninthReg;
  logic [DATA_W-1:0] slaveAddr, addrMask;
  logic [DATA_W-1:0] bcastPat;
  logic givenHit, bcastHit, accept;
  logic ctrlWr, clrFlag, clrErr;

  assign bcastPat = slaveAddr | addrMask;
  assign givenHit = ((shiftReg ^ slaveAddr) & addrMask) == '0;
  assign bcastHit = (shiftReg & bcastPat) == bcastPat;

  always_comb begin
    if (!filterEn)  accept = 1'b1;
    else if (mode9) accept = ninthReg && (givenHit || bcastHit);
    else            accept = strobe.stopOk;
  end

  assign ctrlWr  = regWrEn && (regSel == SEL_CTRL);
  assign clrFlag = ctrlWr && regWrData[CB_CLRFLG];
  assign clrErr  = ctrlWr && regWrData[CB_CLRERR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else if (strobe.shift) begin
      if (strobe.ninth) ninthReg <= strobe.bitVal;
      else shiftReg <= {strobe.bitVal, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode9     <= 1'b0;
      filterEn  <= 1'b0;
      slaveAddr <= '0;
      addrMask  <= '0;
    end else if (regWrEn) begin
      case (regSel)
        SEL_CTRL: begin
          mode9    <= regWrData[CB_MODE9];
          filterEn <= regWrData[CB_FILTER];
        end
        SEL_ADDR: slaveAddr <= regWrData;
        SEL_MASK: addrMask  <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxFlag   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobe.done && accept) begin
        rxData <= shiftReg;
        rxBit9 <= mode9 ? ninthReg : strobe.stopOk;
        rxFlag <= 1'b1;
      end else if (clrFlag) begin
        rxFlag <= 1'b0;
      end
      if (strobe.done && !strobe.stopOk) frameErr <= 1'b1;
      else if (clrErr) frameErr <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_filter_uart_rx.sv
module addr_filter_uart_rx
  import afr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 baudTick,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    rxData,
  output logic                 rxBit9,
  output logic                 rxFlag,
  output logic                 frameErr,
  output logic                 irq
);
  rxStrobe_t strobe;
  logic mode9, filterEn;

  afr_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .mode9(mode9), .strobe(strobe)
  );

  afr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .mode9(mode9), .filterEn(filterEn),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag), .frameErr(frameErr)
  );

  assign irq = rxFlag;
endmodule

// File: rtl/afr_checker.sv
module afr_checker
  import afr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [REG_SEL_W-1:0] regSel,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    rxData,
  input logic                 rxBit9,
  input logic                 rxFlag,
  input logic                 frameErr,
  input logic                 mode9,
  input logic                 filterEn
);
  // R1
  data_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxFlag);

  // R2
  bit9_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxBit9) |-> rxFlag);

  // R5
  filtered_addr_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(mode9 && filterEn)) |-> rxBit9);

  // R10
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFlag) |-> $past(regWrEn && regSel == SEL_CTRL && regWrData[CB_CLRFLG]));

  // R3
  err_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameErr) |-> $past(regWrEn && regSel == SEL_CTRL && regWrData[CB_CLRERR]));
endmodule

bind addr_filter_uart_rx afr_checker #(.DATA_W(DATA_W)) u_afr_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .rxData(rxData), .rxBit9(rxBit9),
  .rxFlag(rxFlag), .frameErr(frameErr), .mode9(mode9), .filterEn(filterEn)
);

// File: tb/addr_filter_uart_rx_bench.sv
module addr_filter_uart_rx_bench;
  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic baudTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] rxData;
  logic rxBit9, rxFlag, frameErr, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  bit mMode9 = 0, mFilt = 0;
  logic [7:0] mAddr = '0, mMask = '0;
  logic [7:0] eData = '0;
  bit eBit9 = 0, eFlag = 0, eErr = 0;

  addr_filter_uart_rx u_addr_filter_uart_rx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag),
    .frameErr(frameErr), .irq(irq)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit addrHit(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
    logic [7:0] b;
    b = a | m;
    return ((d & m) == (a & m)) || ((d & b) == b);
  endfunction

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] dat);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = dat;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic setCtrl(input bit m9, input bit flt, input bit clrF, input bit clrE);
    wrReg(2'd0, {4'b0, clrE, clrF, flt, m9});
    mMode9 = m9; mFilt = flt;
    if (clrF) eFlag = 0;
    if (clrE) eErr = 0;
  endtask

  task automatic checkAll(input string req);
    chk({req, " rxData"}, {8'h0, rxData}, {8'h0, eData});
    chk({req, " rxBit9"}, {15'h0, rxBit9}, {15'h0, eBit9});
    chk({req, " rxFlag"}, {15'h0, rxFlag}, {15'h0, eFlag});
    chk({req, " frameErr"}, {15'h0, frameErr}, {15'h0, eErr});
    chk("R10 irq", {15'h0, irq}, {15'h0, rxFlag});
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit ninth, input bit stopLvl, input string req);
    bit acc;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (mMode9) begin
      rxIn = ninth;
      repeat (BITCLK) @(negedge clk);
    end
    rxIn = stopLvl;
    repeat (BITCLK) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    // model
    if (!stopLvl) eErr = 1;
    if (!mFilt) acc = 1;
    else if (mMode9) acc = ninth && addrHit(d, mAddr, mMask);
    else acc = stopLvl;
    if (acc) begin
      eData = d;
      eBit9 = mMode9 ? ninth : stopLvl;
      eFlag = 1;
    end
    checkAll(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    checkAll("R8 reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: 8-bit, filter off
    sendFrame(8'hA5, 0, 1, "R1 8bit");
    sendFrame(8'h3C, 0, 1, "R1 8bit");
    // R10: flag sticky, cleared by write
    chk("R10 sticky", {15'h0, rxFlag}, 16'h1);
    setCtrl(0, 0, 1, 0);
    checkAll("R10 clear");
    // R3: framing error, filter off still accepts
    sendFrame(8'h81, 0, 0, "R3 bad stop");
    setCtrl(0, 0, 1, 1);
    checkAll("R3 clear");
    // R4: 8-bit filter requires good stop
    setCtrl(0, 1, 0, 0);
    sendFrame(8'h5A, 0, 0, "R4 bad stop rejected");
    sendFrame(8'h77, 0, 1, "R4 good stop");
    setCtrl(0, 1, 1, 1);
    // R11: start glitch
    @(negedge clk);
    rxIn = 1'b0;
    repeat (8) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    checkAll("R11 glitch");
    // R8: reset address/mask transparent in 9-bit filter mode
    setCtrl(1, 1, 0, 0);
    sendFrame(8'h13, 1, 1, "R8 transparent addr");
    setCtrl(1, 1, 1, 0);
    // R5: data frames rejected under filter
    sendFrame(8'hEE, 0, 1, "R5 data rejected");
    // R2: 9-bit filter off
    setCtrl(1, 0, 0, 0);
    sendFrame(8'h42, 0, 1, "R2 ninth low");
    sendFrame(8'h24, 1, 1, "R2 ninth high");
    // R6 / R7 directed
    wrReg(2'd1, 8'hC0); mAddr = 8'hC0;
    wrReg(2'd2, 8'hFD); mMask = 8'hFD;
    setCtrl(1, 1, 1, 1);
    sendFrame(8'hC2, 1, 1, "R6 given match");
    setCtrl(1, 1, 1, 0);
    wrReg(2'd2, 8'hFE); mMask = 8'hFE;
    sendFrame(8'hC2, 1, 1, "R6 given mismatch");
    sendFrame(8'hFF, 1, 1, "R7 broadcast");
    setCtrl(1, 1, 1, 0);
    sendFrame(8'hFE, 1, 1, "R7 broadcast pattern");
    setCtrl(1, 1, 1, 0);
    sendFrame(8'hC1, 1, 1, "R6 given unique");
    // R9: same write path, 9-bit error with filter
    sendFrame(8'hC0, 1, 0, "R3 9bit bad stop");
    setCtrl(1, 1, 1, 1);

    // constrained random
    for (int n = 0; n < 72; n++) begin
      logic [7:0] d;
      int pick;
      if (n % 8 == 0) begin
        logic [7:0] a, m;
        a = 8'($urandom); m = 8'($urandom);
        wrReg(2'd1, a); mAddr = a;
        wrReg(2'd2, m); mMask = m;
        setCtrl($urandom_range(0, 1), $urandom_range(0, 1), 1, 1);
      end
      pick = $urandom_range(0, 3);
      if (pick == 0) d = (mAddr & mMask) | (8'($urandom) & ~mMask);
      else if (pick == 1) d = (mAddr | mMask) | 8'($urandom);
      else d = 8'($urandom);
      sendFrame(d, $urandom_range(0, 1), ($urandom_range(0, 7) != 0), "R9 random");
      if ($urandom_range(0, 1) == 1) begin
        setCtrl(mMode9, mFilt, 1, $urandom_range(0, 1));
        checkAll("R9 random clear");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule